// File: doc/BRIEF.md
# Accumulator Adder and Logic Unit

This block owns the 16-bit accumulator of a small accumulator machine together with its one-bit link/carry flip-flop. Each clock it takes at most one operation, chosen from a set of decoded strobes, and moves the accumulator and link to their new values on the next rising edge. The operations are: add or bitwise-AND a 16-bit memory operand, copy that operand in, and load an 8-bit input character. A 12-bit register-operation field, where each bit names one operation, selects the rest.

The register-operation field covers several groups. It clears or complements the accumulator or the link, rotates the 17-bit link-plus-accumulator ring one place either way, and increments. Four of its bits test the accumulator or link and raise a one-cycle skip request for the sequencer that drives this block. Bus selection, instruction sequencing and halting belong to the surrounding control logic.

Top module: `acc_logic_unit`

## Requirements
- R1: While `rst_n` is low, and on the first edge after, `acc_out` is 0, `link_out` is 0 and `skip_req` is 0.
- R2: Strobe `op_add` sets {link, acc} to the 17-bit sum acc + `opnd_in`, so that link holds the carry-out.
- R3: Strobe `op_and` sets acc to acc & `opnd_in`, and strobe `op_ldo` sets acc to `opnd_in`. Neither changes link.
- R4: Strobe `op_chr` sets acc[7:0] to `char_in` and acc[15:8] to 0, and leaves link unchanged.
- R5: With `rr_valid` high, field bit 11 clears acc, bit 10 clears link, bit 9 inverts acc and bit 8 inverts link. Each changes only its own target.
- R6: Field bit 7 rotates right: acc becomes {link, acc[15:1]} and link becomes the old acc[0]. Field bit 6 rotates left: acc becomes {acc[14:0], link} and link becomes the old acc[15].
- R7: Field bit 5 increments acc modulo 2^16, so 0xFFFF becomes 0x0000, and leaves link unchanged.
- R8: Field bits 4, 3, 2 and 1 test, in that order, acc[15]==0, acc[15]==1, acc==0 and link==0, using the values before the edge. `skip_req` is high for exactly the cycle after the strobe when the test holds. These operations leave acc and link unchanged.
- R9: When several operations are requested together, only one takes effect. The order of precedence is `op_add`, then `op_and`, then `op_ldo`, then `op_chr`, then the field bits from bit 11 down to bit 1.
- R10: Field bit 0 on its own, any field value with `rr_valid` low, and a cycle with no strobe all leave acc and link unchanged and produce no skip request.
- R11: Every result shows on `acc_out`, `link_out` and `skip_req` after the first rising edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_add | input | 1 | Add operand into accumulator |
| op_and | input | 1 | AND operand into accumulator |
| op_ldo | input | 1 | Copy operand into accumulator |
| op_chr | input | 1 | Load input character into low byte |
| rr_valid | input | 1 | Register-operation field is valid this cycle |
| rr_field | input | 12 | One bit per register operation (bit 11 clear acc ... bit 0 halt) |
| opnd_in | input | 16 | Memory operand |
| char_in | input | 8 | Input character |
| acc_out | output | 16 | Accumulator |
| link_out | output | 1 | Link/carry flip-flop |
| skip_req | output | 1 | One-cycle request to skip the next instruction |

## Verification
On every cycle the embedded properties check four things: the 17-bit sum and carry of an add, both rotate directions around the link ring, and that the character load leaves zeros above the low byte. They also check that AND and increment keep the link, that idle and test operations keep both registers, and that the grant is one-hot. They also check that a skip request only follows a test operation. Only the bench scenarios can show the exact value of each test condition at its boundaries, such as acc of 0x8000 against 0x7FFF, or zero against one. The same holds for the precedence outcome when two requests collide and for the return of the skip request to low.

// File: rtl/acc_logic_pkg.sv
package acc_logic_pkg;

  localparam int ACC_W = 16;
  localparam int CHR_W = 8;
  localparam int RR_W  = 12;

  // Operation index doubles as priority: lower index wins.
  typedef enum logic [3:0] {
    OP_NONE = 4'd0,
    OP_ADD  = 4'd1,
    OP_AND  = 4'd2,
    OP_LDO  = 4'd3,
    OP_CHR  = 4'd4,
    OP_CLA  = 4'd5,   // field bit 11
    OP_CLL  = 4'd6,   // field bit 10
    OP_CMA  = 4'd7,   // field bit 9
    OP_CML  = 4'd8,   // field bit 8
    OP_ROR  = 4'd9,   // field bit 7
    OP_ROL  = 4'd10,  // field bit 6
    OP_INC  = 4'd11,  // field bit 5
    OP_TPOS = 4'd12,  // field bit 4
    OP_TNEG = 4'd13,  // field bit 3
    OP_TZER = 4'd14,  // field bit 2
    OP_TLZ  = 4'd15   // field bit 1
  } op_t;

  localparam int OP_N = 16;

  // Field bit b (RR_W-1 .. 1) maps to operation index OP_N - RR_W + (RR_W-1-b) + 1.
  function automatic int field_to_index(input int b);
    return OP_N - 1 - (b - 1);
  endfunction

  function automatic logic is_test_op(input op_t op);
    return (op == OP_TPOS) || (op == OP_TNEG) || (op == OP_TZER) || (op == OP_TLZ);
  endfunction

endpackage

// File: rtl/acc_op_select.sv
module acc_op_select
  import acc_logic_pkg::*;
#(
  parameter int FIELD_W = RR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_add,
  input  logic               op_and,
  input  logic               op_ldo,
  input  logic               op_chr,
  input  logic               rr_valid,
  input  logic [FIELD_W-1:0] rr_field,
  output logic [OP_N-1:0]    grant,
  output op_t                sel_op
);

  logic [OP_N-1:0] req;
  logic            mem_any;

  assign mem_any = op_add | op_and | op_ldo | op_chr;

  always_comb begin
    req                = '0;
    req[OP_ADD]        = op_add;
    req[OP_AND]        = op_and;
    req[OP_LDO]        = op_ldo;
    req[OP_CHR]        = op_chr;
    for (int b = FIELD_W - 1; b >= 1; b--) begin
      req[field_to_index(b)] = rr_valid & rr_field[b];
    end
  end

  // Fixed priority: the lowest set index wins.
  always_comb begin
    grant = '0;
    for (int i = OP_N - 1; i >= 1; i--) begin
      if (req[i]) grant = '0;
      if (req[i]) grant[i] = 1'b1;
    end
  end

  always_comb begin
    sel_op = OP_NONE;
    for (int i = 1; i < OP_N; i++) begin
      if (grant[i]) sel_op = op_t'(i);
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R9

  AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0); // R9

  AST_ADD_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
    op_add |-> sel_op == OP_ADD); // R9

  AST_FIELD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rr_valid && !mem_any) |-> sel_op == OP_NONE); // R10

  AST_HALT_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_valid && rr_field == FIELD_W'(1) && !mem_any) |-> sel_op == OP_NONE); // R10

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_logic_pkg::*;
#(
  parameter int DATA_W = ACC_W,
  parameter int CHAR_W = CHR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_t               sel_op,
  input  logic [DATA_W-1:0] opnd,
  input  logic [CHAR_W-1:0] chr,
  output logic [DATA_W-1:0] acc_q,
  output logic              link_q
);

  localparam int PAD_W = DATA_W - CHAR_W;

  // Result is packed as {link, acc}.
  function automatic logic [DATA_W:0] add_with_carry(input logic [DATA_W-1:0] a,
                                                     input logic [DATA_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [DATA_W:0] rotate_right(input logic [DATA_W-1:0] a, input logic l);
    return {a[0], l, a[DATA_W-1:1]};
  endfunction

  function automatic logic [DATA_W:0] rotate_left(input logic [DATA_W-1:0] a, input logic l);
    return {a, l};
  endfunction

  function automatic logic [DATA_W:0] next_state(input op_t op,
                                                 input logic [DATA_W-1:0] a,
                                                 input logic l,
                                                 input logic [DATA_W-1:0] d,
                                                 input logic [CHAR_W-1:0] c);
    logic [DATA_W:0] r;
    r = {l, a};
    case (op)
      OP_ADD: r = add_with_carry(a, d);
      OP_AND: r = {l, a & d};
      OP_LDO: r = {l, d};
      OP_CHR: r = {l, {PAD_W{1'b0}}, c};
      OP_CLA: r = {l, {DATA_W{1'b0}}};
      OP_CLL: r = {1'b0, a};
      OP_CMA: r = {l, ~a};
      OP_CML: r = {~l, a};
      OP_ROR: r = rotate_right(a, l);
      OP_ROL: r = rotate_left(a, l);
      OP_INC: r = {l, a + DATA_W'(1)};
      default: r = {l, a};
    endcase
    return r;
  endfunction

  logic [DATA_W:0] nxt;
  logic            will_change;

  assign nxt         = next_state(sel_op, acc_q, link_q, opnd, chr);
  assign will_change = (sel_op != OP_NONE) && !is_test_op(sel_op);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      link_q <= 1'b0;
    end else if (will_change) begin
      {link_q, acc_q} <= nxt;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (acc_q == '0 && !link_q)); // R1

  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    sel_op == OP_ADD |=> {link_q, acc_q} == ({1'b0, $past(acc_q)} + {1'b0, $past(opnd)})); // R2

  AST_AND_LINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sel_op == OP_AND |=> (link_q == $past(link_q) && acc_q == ($past(acc_q) & $past(opnd)))); // R3

  AST_CHR_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sel_op == OP_CHR |=> (acc_q[DATA_W-1:CHAR_W] == '0 && acc_q[CHAR_W-1:0] == $past(chr)
                          && $stable(link_q))); // R4

  AST_ROR_RING: assert property (@(posedge clk) disable iff (!rst_n)
    sel_op == OP_ROR |=> {acc_q, link_q} == {$past(link_q), $past(acc_q)}); // R6

  AST_ROL_RING: assert property (@(posedge clk) disable iff (!rst_n)
    sel_op == OP_ROL |=> {link_q, acc_q} == {$past(acc_q), $past(link_q)}); // R6

  AST_INC_LINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sel_op == OP_INC |=> $stable(link_q)); // R7

  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    is_test_op(sel_op) |=> ($stable(acc_q) && $stable(link_q))); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sel_op == OP_NONE |=> ($stable(acc_q) && $stable(link_q))); // R10

endmodule

// File: rtl/acc_skip_unit.sv
module acc_skip_unit
  import acc_logic_pkg::*;
#(
  parameter int DATA_W = ACC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_t               sel_op,
  input  logic [DATA_W-1:0] acc_q,
  input  logic              link_q,
  output logic              skip_q
);

  function automatic logic test_holds(input op_t op, input logic [DATA_W-1:0] a, input logic l);
    case (op)
      OP_TPOS: return !a[DATA_W-1];
      OP_TNEG: return a[DATA_W-1];
      OP_TZER: return a == '0;
      OP_TLZ:  return !l;
      default: return 1'b0;
    endcase
  endfunction

  logic test_sel;
  logic test_pass;

  assign test_sel  = is_test_op(sel_op);
  assign test_pass = test_holds(sel_op, acc_q, link_q);

  always_ff @(posedge clk) begin
    if (!rst_n) skip_q <= 1'b0;
    else        skip_q <= test_pass;
  end

  AST_SKIP_FROM_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    skip_q |-> $past(test_sel)); // R8

  AST_ZERO_TEST_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_op == OP_TZER && acc_q == '0) |=> skip_q); // R8

  AST_NO_TEST_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    !test_sel |=> !skip_q); // R10

endmodule

// File: rtl/acc_logic_unit.sv
module acc_logic_unit
  import acc_logic_pkg::*;
#(
  parameter int DATA_W  = ACC_W,
  parameter int CHAR_W  = CHR_W,
  parameter int FIELD_W = RR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_add,
  input  logic               op_and,
  input  logic               op_ldo,
  input  logic               op_chr,
  input  logic               rr_valid,
  input  logic [FIELD_W-1:0] rr_field,
  input  logic [DATA_W-1:0]  opnd_in,
  input  logic [CHAR_W-1:0]  char_in,
  output logic [DATA_W-1:0]  acc_out,
  output logic               link_out,
  output logic               skip_req
);

  logic [OP_N-1:0] grant;
  op_t             sel_op;

  acc_op_select #(.FIELD_W(FIELD_W)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_add   (op_add),
    .op_and   (op_and),
    .op_ldo   (op_ldo),
    .op_chr   (op_chr),
    .rr_valid (rr_valid),
    .rr_field (rr_field),
    .grant    (grant),
    .sel_op   (sel_op)
  );

  acc_datapath #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_op (sel_op),
    .opnd   (opnd_in),
    .chr    (char_in),
    .acc_q  (acc_out),
    .link_q (link_out)
  );

  acc_skip_unit #(.DATA_W(DATA_W)) u_skip (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_op (sel_op),
    .acc_q  (acc_out),
    .link_q (link_out),
    .skip_q (skip_req)
  );

  AST_SKIP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    skip_req |-> ($stable(acc_out) && $stable(link_out))); // R11

endmodule

// File: tb/acc_logic_unit_test.sv
module acc_logic_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_add = 1'b0, op_and = 1'b0, op_ldo = 1'b0, op_chr = 1'b0;
  logic        rr_valid = 1'b0;
  logic [11:0] rr_field = '0;
  logic [15:0] opnd_in = '0;
  logic [7:0]  char_in = '0;
  logic [15:0] acc_out;
  logic        link_out;
  logic        skip_req;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  acc_logic_unit uut (
    .clk(clk), .rst_n(rst_n),
    .op_add(op_add), .op_and(op_and), .op_ldo(op_ldo), .op_chr(op_chr),
    .rr_valid(rr_valid), .rr_field(rr_field),
    .opnd_in(opnd_in), .char_in(char_in),
    .acc_out(acc_out), .link_out(link_out), .skip_req(skip_req)
  );

  // stb = {rr_valid, op_chr, op_ldo, op_and, op_add}
  typedef struct packed {
    logic [4:0]  stb;
    logic [11:0] fld;
    logic [15:0] ac0;
    logic        lk0;
    logic [15:0] opnd;
    logic [7:0]  chr;
    logic [15:0] xac;
    logic        xlk;
    logic        xsk;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{5'b00001, 12'h000, 16'h1234, 1'b0, 16'h0F0F, 8'h00, 16'h2143, 1'b0, 1'b0, 8'd2},  // R2
    '{5'b00001, 12'h000, 16'hFFFF, 1'b0, 16'h0001, 8'h00, 16'h0000, 1'b1, 1'b0, 8'd2},  // R2 carry
    '{5'b00001, 12'h000, 16'h0001, 1'b1, 16'h0001, 8'h00, 16'h0002, 1'b0, 1'b0, 8'd2},  // R2 link overwritten
    '{5'b00010, 12'h000, 16'hF0F0, 1'b1, 16'h3C3C, 8'h00, 16'h3030, 1'b1, 1'b0, 8'd3},  // R3 and
    '{5'b00100, 12'h000, 16'h1111, 1'b1, 16'hABCD, 8'h00, 16'hABCD, 1'b1, 1'b0, 8'd3},  // R3 copy
    '{5'b01000, 12'h000, 16'hFFFF, 1'b0, 16'h0000, 8'h5A, 16'h005A, 1'b0, 1'b0, 8'd4},  // R4
    '{5'b01000, 12'h000, 16'h0000, 1'b1, 16'h0000, 8'hFF, 16'h00FF, 1'b1, 1'b0, 8'd4},  // R4
    '{5'b10000, 12'h800, 16'h1234, 1'b1, 16'h0000, 8'h00, 16'h0000, 1'b1, 1'b0, 8'd5},  // R5 clear acc
    '{5'b10000, 12'h400, 16'h1234, 1'b1, 16'h0000, 8'h00, 16'h1234, 1'b0, 1'b0, 8'd5},  // R5 clear link
    '{5'b10000, 12'h200, 16'h00FF, 1'b0, 16'h0000, 8'h00, 16'hFF00, 1'b0, 1'b0, 8'd5},  // R5 invert acc
    '{5'b10000, 12'h100, 16'h00FF, 1'b0, 16'h0000, 8'h00, 16'h00FF, 1'b1, 1'b0, 8'd5},  // R5 invert link
    '{5'b10000, 12'h080, 16'h0003, 1'b0, 16'h0000, 8'h00, 16'h0001, 1'b1, 1'b0, 8'd6},  // R6 right
    '{5'b10000, 12'h080, 16'h8000, 1'b1, 16'h0000, 8'h00, 16'hC000, 1'b0, 1'b0, 8'd6},  // R6 right
    '{5'b10000, 12'h040, 16'h8001, 1'b0, 16'h0000, 8'h00, 16'h0002, 1'b1, 1'b0, 8'd6},  // R6 left
    '{5'b10000, 12'h040, 16'h4000, 1'b1, 16'h0000, 8'h00, 16'h8001, 1'b0, 1'b0, 8'd6},  // R6 left
    '{5'b10000, 12'h020, 16'hFFFF, 1'b0, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 8'd7},  // R7 wrap
    '{5'b10000, 12'h020, 16'h7FFF, 1'b1, 16'h0000, 8'h00, 16'h8000, 1'b1, 1'b0, 8'd7},  // R7
    '{5'b10000, 12'h010, 16'h7FFF, 1'b0, 16'h0000, 8'h00, 16'h7FFF, 1'b0, 1'b1, 8'd8},  // R8 positive
    '{5'b10000, 12'h010, 16'h8000, 1'b0, 16'h0000, 8'h00, 16'h8000, 1'b0, 1'b0, 8'd8},  // R8
    '{5'b10000, 12'h008, 16'h8000, 1'b1, 16'h0000, 8'h00, 16'h8000, 1'b1, 1'b1, 8'd8},  // R8 negative
    '{5'b10000, 12'h008, 16'h7FFF, 1'b1, 16'h0000, 8'h00, 16'h7FFF, 1'b1, 1'b0, 8'd8},  // R8
    '{5'b10000, 12'h004, 16'h0000, 1'b1, 16'h0000, 8'h00, 16'h0000, 1'b1, 1'b1, 8'd8},  // R8 zero
    '{5'b10000, 12'h004, 16'h0001, 1'b1, 16'h0000, 8'h00, 16'h0001, 1'b1, 1'b0, 8'd8},  // R8
    '{5'b10000, 12'h002, 16'h1234, 1'b0, 16'h0000, 8'h00, 16'h1234, 1'b0, 1'b1, 8'd8},  // R8 link zero
    '{5'b10000, 12'h002, 16'h1234, 1'b1, 16'h0000, 8'h00, 16'h1234, 1'b1, 1'b0, 8'd8},  // R8
    '{5'b10000, 12'h001, 16'h1234, 1'b1, 16'h0000, 8'h00, 16'h1234, 1'b1, 1'b0, 8'd10}, // R10 halt bit
    '{5'b00000, 12'h800, 16'h1234, 1'b1, 16'h0000, 8'h00, 16'h1234, 1'b1, 1'b0, 8'd10}, // R10 not valid
    '{5'b10000, 12'hA00, 16'h1234, 1'b0, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 8'd9},  // R9 bit 11 over 9
    '{5'b10000, 12'h0C0, 16'h0003, 1'b0, 16'h0000, 8'h00, 16'h0001, 1'b1, 1'b0, 8'd9},  // R9 right over left
    '{5'b10000, 12'h030, 16'h7FFF, 1'b0, 16'h0000, 8'h00, 16'h8000, 1'b0, 1'b0, 8'd9},  // R9 inc over test
    '{5'b00011, 12'h000, 16'h00FF, 1'b0, 16'h0F01, 8'h00, 16'h1000, 1'b0, 1'b0, 8'd9},  // R9 add over and
    '{5'b00110, 12'h000, 16'h00FF, 1'b0, 16'h0F01, 8'h00, 16'h0001, 1'b0, 1'b0, 8'd9},  // R9 and over copy
    '{5'b11100, 12'h800, 16'hFFFF, 1'b0, 16'h1234, 8'h77, 16'h1234, 1'b0, 1'b0, 8'd9}   // R9 copy over char, field
  };

  task automatic check(input string tag, input logic [15:0] ac, input logic lk, input logic sk,
                       input logic [15:0] xac, input logic xlk, input logic xsk);
    checks++;
    if (ac !== xac || lk !== xlk || sk !== xsk) begin
      fails++;
      $display("FAIL %s: acc=%h link=%b skip=%b expected acc=%h link=%b skip=%b",
               tag, ac, lk, sk, xac, xlk, xsk);
    end
  endtask

  // Called at a falling edge; holds inputs through one rising edge.
  task automatic step(input logic [4:0] stb, input logic [11:0] fld,
                      input logic [15:0] d, input logic [7:0] c);
    {rr_valid, op_chr, op_ldo, op_and, op_add} = stb;
    rr_field = fld;
    opnd_in  = d;
    char_in  = c;
    @(negedge clk);
    {rr_valid, op_chr, op_ldo, op_and, op_add} = '0;
    rr_field = '0;
  endtask

  task automatic preset(input logic [15:0] ac, input logic lk);
    step(5'b00100, 12'h000, ac, 8'h00);
    step(5'b10000, 12'h400, 16'h0, 8'h00);
    if (lk) step(5'b10000, 12'h100, 16'h0, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", acc_out, link_out, skip_req, 16'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", acc_out, link_out, skip_req, 16'h0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      preset(VECS[i].ac0, VECS[i].lk0);
      step(VECS[i].stb, VECS[i].fld, VECS[i].opnd, VECS[i].chr);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), acc_out, link_out, skip_req,
            VECS[i].xac, VECS[i].xlk, VECS[i].xsk);
      @(negedge clk);
      // R8 pulse lasts one cycle; R11 nothing changes with no strobe
      check($sformatf("R8 idle after vector %0d", i), acc_out, link_out, skip_req,
            VECS[i].xac, VECS[i].xlk, 1'b0);
    end

    // R11: back-to-back operations each land on their own edge
    preset(16'h0000, 1'b0);
    step(5'b10000, 12'h004, 16'h0, 8'h00);
    check("R11 test then", acc_out, link_out, skip_req, 16'h0000, 1'b0, 1'b1);
    step(5'b10000, 12'h020, 16'h0, 8'h00);
    check("R11 inc next edge", acc_out, link_out, skip_req, 16'h0001, 1'b0, 1'b0);
    step(5'b10000, 12'h004, 16'h0, 8'h00);
    check("R8 nonzero after inc", acc_out, link_out, skip_req, 16'h0001, 1'b0, 1'b0);

    // R1: reset while holding a value
    preset(16'hBEEF, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", acc_out, link_out, skip_req, 16'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule